// File: doc/BRIEF.md
# Dual-Channel Disk I/O Address Decoder

This block sits behind the configuration register file of a two-channel disk controller. Each cycle it may receive one 16-bit I/O address with a valid strobe. It decides whether that address selects a channel's task-file (command) block, a channel's control/alternate-status port, or one of the two register slots in the bus-master window. The result is a single registered hit: a kind flag, a channel index and a 3-bit register offset. These go to the channel logic downstream.

Each channel has its own mode bit. With the bit clear, the channel uses the fixed compatibility addresses. With the bit set, it uses the command and control bases that software programmed into its base-address registers. A global I/O enable gates every decode. A per-channel enable gates only that channel's command and control decodes, so the bus-master window follows the global enable alone.

The block also routes each channel's drive interrupt. A compatibility-mode channel drives its own dedicated legacy line. Native-mode channels share one level-sensitive interrupt output.

Top module: `ide_addr_decoder`

## Requirements
- R1: With its mode bit clear, channel 0 uses command block 0x1F0–0x1F7 and control port 0x3F6, and channel 1 uses command block 0x170–0x177 and control port 0x376.
- R2: With its mode bit set, a channel uses its programmed command base and control base with bit 0 forced to zero. The command hit covers the 8 addresses that share bits 15:3 with that base, and hit_off reports addr[2:0].
- R3: A control hit matches exactly one address, and hit_off reads 0 for it. The address one above the control port produces no hit.
- R4: While io_en is 0, no hit of any kind asserts, including bus-master hits.
- R5: chan_en bit c (c = 0 primary, 1 secondary) gates only channel c's command and control decodes. Bus-master hits for channel c still occur while that bit is 0.
- R6: The bus-master window is the 16 addresses sharing bits 15:4 with bm_base. addr[3] selects the channel (0 primary, 1 secondary) and hit_off reports addr[2:0].
- R7: At most one of hit_cmd, hit_ctl and hit_bm asserts per cycle. On overlap the priority is channel 0 before channel 1, and within a channel command before control before bus-master.
- R8: Hits appear on the clock edge after the address is presented with addr_valid high. An address presented with addr_valid low yields no hit.
- R9: irq_leg_pri follows drive_irq[0] while channel 0 is in compatibility mode, and irq_leg_sec follows drive_irq[1] while channel 1 is. Each output is 0 while its channel is native. Both outputs are registered one cycle.
- R10: irq_native is the OR of the drive interrupts of the channels in native mode, registered one cycle. It is 0 when no channel is native.
- R11: During reset every hit and interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_en | input | 1 | Global I/O decode enable |
| chan_en | input | 2 | Per-channel command/control decode enable |
| native_mode | input | 2 | Per-channel mode: 1 = programmed bases, 0 = compatibility |
| cmd_base | input | 2x16 | Programmed command-block base per channel |
| ctl_base | input | 2x16 | Programmed control-port base per channel |
| bm_base | input | 16 | Bus-master window base |
| addr | input | 16 | I/O address |
| addr_valid | input | 1 | Address qualifier |
| drive_irq | input | 2 | Interrupt request from each channel's drives |
| hit_cmd | output | 1 | Command-block hit (registered) |
| hit_ctl | output | 1 | Control-port hit (registered) |
| hit_bm | output | 1 | Bus-master window hit (registered) |
| hit_chan | output | 1 | Channel of the hit, 0 primary, 1 secondary |
| hit_off | output | 3 | Register offset within the target |
| irq_leg_pri | output | 1 | Legacy interrupt line of channel 0 |
| irq_leg_sec | output | 1 | Legacy interrupt line of channel 1 |
| irq_native | output | 1 | Shared native-mode interrupt |

## Verification
Compatibility-mode sweeps walk both command blocks edge to edge and probe each control port and its neighbour, which separates the 8-address and 1-address match widths. Native-mode vectors use bases with bit 0 set and retry the compatibility addresses. These show whether the mode bit swaps the bases and whether bit 0 is masked. Global and per-channel enables are toggled around bus-master addresses, which exposes any coupling of the bus-master window to the channel enables. Deliberately overlapping bases check the priority order among the three hit kinds and the two channels. Interrupt patterns cover every mix of modes, which tells dedicated-line routing apart from the shared output.

// File: rtl/ide_dec_pkg.sv
`timescale 1ns/1ps
package ide_dec_pkg;

  localparam int NUM_CH    = 2;
  localparam int REG_OFF_W = 3;
  localparam int CH_IDX_W  = 1;
  localparam int LEG_W     = 16;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CMD  = 2'd1,
    HIT_CTL  = 2'd2,
    HIT_BM   = 2'd3
  } hit_kind_e;

  function automatic logic [LEG_W-1:0] legacy_cmd_base(input int ch);
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [LEG_W-1:0] legacy_ctl_base(input int ch);
    return (ch == 0) ? 16'h03F6 : 16'h0376;
  endfunction

endpackage

// File: rtl/ide_chan_match.sv
`timescale 1ns/1ps
module ide_chan_match
  import ide_dec_pkg::*;
#(
  parameter int             AW      = 16,
  parameter logic [AW-1:0]  LEG_CMD = '0,
  parameter logic [AW-1:0]  LEG_CTL = '0
) (
  input  logic          en,
  input  logic          native,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] ctl_base,
  output logic          cmd_hit,
  output logic          ctl_hit
);

  localparam logic [AW-1:0] CMD_MASK  = ~((AW'(1) << REG_OFF_W) - AW'(1));
  localparam logic [AW-1:0] BIT0_MASK = ~AW'(1);

  logic [AW-1:0] cmd_eff;
  logic [AW-1:0] ctl_eff;

  always_comb begin
    if (native) begin
      cmd_eff = cmd_base & BIT0_MASK;
      ctl_eff = ctl_base & BIT0_MASK;
    end else begin
      cmd_eff = LEG_CMD;
      ctl_eff = LEG_CTL;
    end
  end

  always_comb begin
    cmd_hit = en && (((addr ^ cmd_eff) & CMD_MASK) == '0);
    ctl_hit = en && (addr == ctl_eff);
  end

endmodule

// File: rtl/ide_bm_match.sv
`timescale 1ns/1ps
module ide_bm_match
  import ide_dec_pkg::*;
#(
  parameter int AW  = 16,
  parameter int NCH = NUM_CH
) (
  input  logic           en,
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  bm_base,
  output logic [NCH-1:0] bm_hit
);

  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int WIN_W    = REG_OFF_W + CH_W;
  localparam logic [AW-1:0] WIN_MASK = ~((AW'(1) << WIN_W) - AW'(1));

  logic win_hit;

  always_comb begin
    win_hit = en && (((addr ^ bm_base) & WIN_MASK) == '0);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    always_comb begin
      bm_hit[c] = win_hit && (addr[REG_OFF_W +: CH_W] == CH_W'(c));
    end
  end

endmodule

// File: rtl/ide_hit_arb.sv
`timescale 1ns/1ps
module ide_hit_arb
  import ide_dec_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int CH_W = CH_IDX_W
) (
  input  logic [NCH-1:0]       cmd_hit,
  input  logic [NCH-1:0]       ctl_hit,
  input  logic [NCH-1:0]       bm_hit,
  input  logic [REG_OFF_W-1:0] off_in,
  output hit_kind_e            kind,
  output logic [CH_W-1:0]      chan,
  output logic [REG_OFF_W-1:0] off
);

  // Later assignments win: walk from the lowest priority upward.
  always_comb begin
    kind = HIT_NONE;
    chan = '0;
    off  = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (bm_hit[c]) begin
        kind = HIT_BM;
        chan = CH_W'(c);
        off  = off_in;
      end
      if (ctl_hit[c]) begin
        kind = HIT_CTL;
        chan = CH_W'(c);
        off  = '0;
      end
      if (cmd_hit[c]) begin
        kind = HIT_CMD;
        chan = CH_W'(c);
        off  = off_in;
      end
    end
  end

endmodule

// File: rtl/ide_irq_route.sv
`timescale 1ns/1ps
module ide_irq_route
  import ide_dec_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic [NCH-1:0] drive_irq,
  input  logic [NCH-1:0] native,
  output logic [NCH-1:0] irq_leg,
  output logic           irq_nat
);

  for (genvar c = 0; c < NCH; c++) begin : g_leg
    always_comb begin
      irq_leg[c] = drive_irq[c] && !native[c];
    end
  end

  always_comb begin
    irq_nat = |(drive_irq & native);
  end

endmodule

// File: rtl/ide_addr_decoder.sv
`timescale 1ns/1ps
module ide_addr_decoder
  import ide_dec_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         io_en,
  input  logic [NUM_CH-1:0]            chan_en,
  input  logic [NUM_CH-1:0]            native_mode,
  input  logic [NUM_CH-1:0][AW-1:0]    cmd_base,
  input  logic [NUM_CH-1:0][AW-1:0]    ctl_base,
  input  logic [AW-1:0]                bm_base,
  input  logic [AW-1:0]                addr,
  input  logic                         addr_valid,
  input  logic [NUM_CH-1:0]            drive_irq,
  output logic                         hit_cmd,
  output logic                         hit_ctl,
  output logic                         hit_bm,
  output logic [CH_IDX_W-1:0]          hit_chan,
  output logic [REG_OFF_W-1:0]         hit_off,
  output logic                         irq_leg_pri,
  output logic                         irq_leg_sec,
  output logic                         irq_native
);

  localparam int NCH = NUM_CH;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  // Decode stage
  logic           dec_en;
  logic [NCH-1:0] cmd_hit;
  logic [NCH-1:0] ctl_hit;
  logic [NCH-1:0] bm_hit;

  assign dec_en = io_en && addr_valid;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ide_chan_match #(
      .AW      (AW),
      .LEG_CMD (AW'(legacy_cmd_base(c))),
      .LEG_CTL (AW'(legacy_ctl_base(c)))
    ) i_match (
      .en       (dec_en && chan_en[c]),
      .native   (native_mode[c]),
      .addr     (addr),
      .cmd_base (cmd_base[c]),
      .ctl_base (ctl_base[c]),
      .cmd_hit  (cmd_hit[c]),
      .ctl_hit  (ctl_hit[c])
    );
  end

  ide_bm_match #(
    .AW  (AW),
    .NCH (NCH)
  ) i_bm (
    .en      (dec_en),
    .addr    (addr),
    .bm_base (bm_base),
    .bm_hit  (bm_hit)
  );

  hit_kind_e                kind_nxt;
  logic [CH_IDX_W-1:0]      chan_nxt;
  logic [REG_OFF_W-1:0]     off_nxt;

  ide_hit_arb #(
    .NCH  (NCH),
    .CH_W (CH_IDX_W)
  ) i_arb (
    .cmd_hit (cmd_hit),
    .ctl_hit (ctl_hit),
    .bm_hit  (bm_hit),
    .off_in  (addr[REG_OFF_W-1:0]),
    .kind    (kind_nxt),
    .chan    (chan_nxt),
    .off     (off_nxt)
  );

  logic [NCH-1:0] irq_leg_nxt;
  logic           irq_nat_nxt;

  ide_irq_route #(
    .NCH (NCH)
  ) i_irq (
    .drive_irq (drive_irq),
    .native    (native_mode),
    .irq_leg   (irq_leg_nxt),
    .irq_nat   (irq_nat_nxt)
  );

  // Output register stage
  hit_kind_e            kind_q;
  logic [CH_IDX_W-1:0]  chan_q;
  logic [REG_OFF_W-1:0] off_q;
  logic [NCH-1:0]       irq_leg_q;
  logic                 irq_nat_q;
  logic                 kind_upd;
  logic                 tgt_upd;

  always_comb begin
    kind_upd = addr_valid || (kind_q != HIT_NONE);
    tgt_upd  = addr_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      kind_q    <= HIT_NONE;
      chan_q    <= '0;
      off_q     <= '0;
      irq_leg_q <= '0;
      irq_nat_q <= 1'b0;
    end else begin
      if (kind_upd) begin
        kind_q <= kind_nxt;
      end
      if (tgt_upd) begin
        chan_q <= chan_nxt;
        off_q  <= off_nxt;
      end
      irq_leg_q <= irq_leg_nxt;
      irq_nat_q <= irq_nat_nxt;
    end
  end

  assign hit_cmd     = (kind_q == HIT_CMD);
  assign hit_ctl     = (kind_q == HIT_CTL);
  assign hit_bm      = (kind_q == HIT_BM);
  assign hit_chan    = chan_q;
  assign hit_off     = off_q;
  assign irq_leg_pri = irq_leg_q[0];
  assign irq_leg_sec = irq_leg_q[1];
  assign irq_native  = irq_nat_q;

endmodule

// File: rtl/ide_addr_decoder_chk.sv
`timescale 1ns/1ps
module ide_addr_decoder_chk
  import ide_dec_pkg::*;
#(
  parameter int AW = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      io_en,
  input logic [NUM_CH-1:0]         chan_en,
  input logic [NUM_CH-1:0]         native_mode,
  input logic [AW-1:0]             addr,
  input logic                      addr_valid,
  input logic [NUM_CH-1:0]         drive_irq,
  input logic                      hit_cmd,
  input logic                      hit_ctl,
  input logic                      hit_bm,
  input logic [CH_IDX_W-1:0]       hit_chan,
  input logic [REG_OFF_W-1:0]      hit_off,
  input logic                      irq_leg_pri,
  input logic                      irq_leg_sec,
  input logic                      irq_native
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  // R7
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_cmd, hit_ctl, hit_bm}));

  // R4
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(io_en)) |-> !(hit_cmd || hit_ctl || hit_bm));

  // R8
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(addr_valid)) |-> !(hit_cmd || hit_ctl || hit_bm));

  // R5
  pri_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (hit_cmd || hit_ctl) && (hit_chan == 1'b0)) |-> $past(chan_en[0]));

  // R5
  sec_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (hit_cmd || hit_ctl) && (hit_chan == 1'b1)) |-> $past(chan_en[1]));

  // R1
  legacy_pri_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(addr_valid && io_en && chan_en[0] && !native_mode[0]
                    && (addr[AW-1:3] == 13'h003E)))
    |-> (hit_cmd && (hit_chan == 1'b0) && (hit_off == $past(addr[2:0]))));

  // R6
  bm_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hit_bm) |-> ((hit_chan == $past(addr[3])) && (hit_off == $past(addr[2:0]))));

  // R3
  ctl_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |-> (hit_off == '0));

  // R9
  leg_pri_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq_leg_pri == $past(drive_irq[0] && !native_mode[0])));

  // R9
  leg_sec_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq_leg_sec == $past(drive_irq[1] && !native_mode[1])));

  // R10
  native_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(native_mode == '0)) |-> !irq_native);

endmodule

bind ide_addr_decoder ide_addr_decoder_chk #(.AW(AW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .io_en       (io_en),
  .chan_en     (chan_en),
  .native_mode (native_mode),
  .addr        (addr),
  .addr_valid  (addr_valid),
  .drive_irq   (drive_irq),
  .hit_cmd     (hit_cmd),
  .hit_ctl     (hit_ctl),
  .hit_bm      (hit_bm),
  .hit_chan    (hit_chan),
  .hit_off     (hit_off),
  .irq_leg_pri (irq_leg_pri),
  .irq_leg_sec (irq_leg_sec),
  .irq_native  (irq_native)
);

// File: tb/test_ide_addr_decoder.sv
`timescale 1ns/1ps
module test_ide_addr_decoder;

  logic             clk;
  logic             rst_n;
  logic             io_en;
  logic [1:0]       chan_en;
  logic [1:0]       native_mode;
  logic [1:0][15:0] cmd_base;
  logic [1:0][15:0] ctl_base;
  logic [15:0]      bm_base;
  logic [15:0]      addr;
  logic             addr_valid;
  logic [1:0]       drive_irq;
  logic             hit_cmd, hit_ctl, hit_bm;
  logic [0:0]       hit_chan;
  logic [2:0]       hit_off;
  logic             irq_leg_pri, irq_leg_sec, irq_native;

  ide_addr_decoder i_ide_addr_decoder (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .chan_en(chan_en),
    .native_mode(native_mode), .cmd_base(cmd_base), .ctl_base(ctl_base),
    .bm_base(bm_base), .addr(addr), .addr_valid(addr_valid),
    .drive_irq(drive_irq), .hit_cmd(hit_cmd), .hit_ctl(hit_ctl),
    .hit_bm(hit_bm), .hit_chan(hit_chan), .hit_off(hit_off),
    .irq_leg_pri(irq_leg_pri), .irq_leg_sec(irq_leg_sec),
    .irq_native(irq_native)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic       cmd, ctl, bm;
    logic       chan;
    logic [2:0] off;
    logic       i14, i15, inat;
    string      req;
  } exp_t;

  exp_t sb[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // shadow configuration, copied to the pins at a falling edge
  logic             s_io;
  logic [1:0]       s_chen, s_nat, s_irq;
  logic [1:0][15:0] s_cmd, s_ctl;
  logic [15:0]      s_bm;

  function automatic exp_t model(input logic [15:0] a, input logic v);
    exp_t e;
    logic found;
    logic [15:0] cb, kb;
    e.cmd = 0; e.ctl = 0; e.bm = 0; e.chan = 0; e.off = 0;
    found = 0;
    for (int c = 0; c < 2; c++) begin
      cb = s_nat[c] ? (s_cmd[c] & 16'hFFFE) : ((c == 0) ? 16'h01F0 : 16'h0170);
      kb = s_nat[c] ? (s_ctl[c] & 16'hFFFE) : ((c == 0) ? 16'h03F6 : 16'h0376);
      if (!found && v && s_io) begin
        if (s_chen[c] && a[15:3] == cb[15:3]) begin
          e.cmd = 1; e.chan = c[0]; e.off = a[2:0]; found = 1;
        end else if (s_chen[c] && a == kb) begin
          e.ctl = 1; e.chan = c[0]; e.off = 0; found = 1;
        end else if (a[15:4] == s_bm[15:4] && a[3] == c[0]) begin
          e.bm = 1; e.chan = c[0]; e.off = a[2:0]; found = 1;
        end
      end
    end
    e.i14  = s_irq[0] && !s_nat[0];
    e.i15  = s_irq[1] && !s_nat[1];
    e.inat = |(s_irq & s_nat);
    return e;
  endfunction

  task automatic apply(input logic [15:0] a, input logic v, input string req);
    exp_t e;
    @(negedge clk);
    io_en = s_io; chan_en = s_chen; native_mode = s_nat;
    cmd_base = s_cmd; ctl_base = s_ctl; bm_base = s_bm;
    drive_irq = s_irq; addr = a; addr_valid = v;
    e = model(a, v);
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic compare(input exp_t e);
    logic anyh;
    n_vec++;
    anyh = e.cmd || e.ctl || e.bm;
    if (hit_cmd !== e.cmd || hit_ctl !== e.ctl || hit_bm !== e.bm ||
        (anyh && (hit_chan !== e.chan || hit_off !== e.off)) ||
        irq_leg_pri !== e.i14 || irq_leg_sec !== e.i15 || irq_native !== e.inat) begin
      n_fail++;
      $display("FAIL %s: got cmd%0b ctl%0b bm%0b ch%0d off%0d irq %0b%0b%0b, exp cmd%0b ctl%0b bm%0b ch%0d off%0d irq %0b%0b%0b",
               e.req, hit_cmd, hit_ctl, hit_bm, hit_chan, hit_off,
               irq_leg_pri, irq_leg_sec, irq_native,
               e.cmd, e.ctl, e.bm, e.chan, e.off, e.i14, e.i15, e.inat);
    end
  endtask

  // monitor: one item per cycle, sampled after the register update
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        compare(e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    finish_run();
  end

  initial begin
    exp_t r;
    rst_n = 0; io_en = 1; chan_en = 2'b11; native_mode = 0;
    cmd_base = '0; ctl_base = '0; bm_base = 16'hE005;
    addr = 16'h01F0; addr_valid = 1; drive_irq = 2'b11;
    s_io = 1; s_chen = 2'b11; s_nat = 2'b00; s_irq = 2'b00;
    s_cmd = '0; s_ctl = '0; s_bm = 16'hE005;
    repeat (3) @(negedge clk);
    // R11 reset state with active-looking inputs
    r.cmd = 0; r.ctl = 0; r.bm = 0; r.chan = 0; r.off = 0;
    r.i14 = 0; r.i15 = 0; r.inat = 0; r.req = "R11 reset";
    compare(r);
    rst_n = 1;
    addr_valid = 0; drive_irq = 0;
    repeat (4) @(negedge clk);

    // R1 compatibility command blocks, edges and outside
    apply(16'h01F0, 1, "R1 pri cmd low");
    apply(16'h01F7, 1, "R1 pri cmd high");
    apply(16'h01F8, 1, "R1 pri cmd above");
    apply(16'h0170, 1, "R1 sec cmd low");
    apply(16'h0175, 1, "R1 sec cmd mid");
    // R3 control ports and neighbours
    apply(16'h03F6, 1, "R3 pri ctl");
    apply(16'h03F7, 1, "R3 pri ctl plus one");
    apply(16'h0376, 1, "R3 sec ctl");
    apply(16'h0377, 1, "R3 sec ctl plus one");
    // R6 bus-master window
    apply(16'hE003, 1, "R6 bm pri slot");
    apply(16'hE00A, 1, "R6 bm sec slot");
    apply(16'hE010, 1, "R6 bm beyond window");
    // R8 invalid strobe
    apply(16'h01F2, 0, "R8 addr_valid low");
    // R4 global enable off
    s_io = 0;
    apply(16'h01F1, 1, "R4 io off cmd");
    apply(16'hE002, 1, "R4 io off bm");
    s_io = 1;
    // R5 channel enables
    s_chen = 2'b10;
    apply(16'h01F1, 1, "R5 pri disabled cmd");
    apply(16'h03F6, 1, "R5 pri disabled ctl");
    apply(16'hE004, 1, "R5 bm still decodes");
    apply(16'h0171, 1, "R5 sec unaffected");
    s_chen = 2'b01;
    apply(16'h0376, 1, "R5 sec disabled ctl");
    apply(16'hE00C, 1, "R5 sec bm still decodes");
    s_chen = 2'b11;
    // R2 native bases with bit 0 set
    s_nat = 2'b11;
    s_cmd[0] = 16'hC001; s_ctl[0] = 16'hC00D;
    s_cmd[1] = 16'hC021; s_ctl[1] = 16'hC02F;
    apply(16'hC000, 1, "R2 native pri cmd low");
    apply(16'hC007, 1, "R2 native pri cmd high");
    apply(16'hC00C, 1, "R2 native pri ctl masked");
    apply(16'hC00D, 1, "R2 native ctl odd addr");
    apply(16'hC024, 1, "R2 native sec cmd");
    apply(16'hC02E, 1, "R2 native sec ctl");
    apply(16'h01F0, 1, "R2 legacy addr in native");
    apply(16'h0376, 1, "R2 legacy ctl in native");
    // R7 overlaps
    s_nat = 2'b01; s_cmd[0] = 16'h0170;
    apply(16'h0172, 1, "R7 pri cmd over sec cmd");
    s_nat = 2'b00; s_bm = 16'h03F0;
    apply(16'h03F6, 1, "R7 ctl over bm");
    apply(16'h03F2, 1, "R7 bm alone");
    s_bm = 16'h0170;
    apply(16'h0171, 1, "R7 pri bm over sec cmd");
    apply(16'h0179, 1, "R7 bm sec slot");
    s_bm = 16'hE000;
    // R9 / R10 interrupt routing
    s_irq = 2'b01;
    apply(16'h0000, 0, "R9 pri legacy irq");
    s_irq = 2'b10;
    apply(16'h0000, 0, "R9 sec legacy irq");
    s_irq = 2'b11;
    apply(16'h0000, 0, "R9 both legacy irq");
    s_nat = 2'b01; s_irq = 2'b01;
    apply(16'h0000, 0, "R10 pri native irq");
    s_irq = 2'b11;
    apply(16'h0000, 0, "R10 mixed modes");
    s_nat = 2'b11; s_irq = 2'b10;
    apply(16'h0000, 0, "R10 sec native irq");
    s_irq = 2'b00;
    apply(16'h0000, 0, "R10 native idle");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule